// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block is the bus-master side of a write port to asynchronous external memory or memory-mapped peripherals. An internal agent presents one write at a time on a ready/valid port, with an address, a data word and a bank number. The sequencer first presents the address and one active-low bank select for a setup cycle, with an address clock pulse. It then pulls the active-low write strobe down and enables the data-bus drivers.

The strobe stays low for a programmed number of wait states. After those have elapsed it stays low for as long as the external acknowledge is sampled low. After the strobe rises, the data bus stays driven for one more cycle. Two options can follow: a hold cycle that keeps address and select with the data bus released, and a bus-idle cycle with everything released. The sequencer then returns to idle and pulses a completion flag.

A small configuration register holds the wait-state count and the two option bits. Its contents are captured when a request is accepted, so a write to it affects only later requests.

Top module: `ext_wr_seq`

## Requirements
- R1: The cycle after a request is accepted, the address equals the request address and the bank select is active while the write strobe is still high. The strobe falls on the following cycle, and the address does not change while any select is active.
- R2: With the acknowledge high, the write strobe is low for exactly W+1 consecutive cycles. W is the wait-state count held in the configuration register when the request was accepted (0 to 2^WAIT_W-1).
- R3: The acknowledge input has no effect during the first W strobe-low cycles. A low acknowledge there does not lengthen the strobe.
- R4: Once the wait states have elapsed, each clock edge that samples the acknowledge low keeps the strobe low for one more cycle. The strobe rises after the first edge that samples it high.
- R5: The data-bus enable is high exactly while the strobe is low and for the one cycle after the strobe rises. While it is high, the data output equals the request data.
- R6: The bank select output is active-low, one bit per bank. The bit whose index equals the request's bank number is the only one driven low, and it is low from the setup cycle until the end of the release or hold cycle.
- R7: With the hold option set, one extra cycle follows the data-release cycle. In it, the select and address are held, the data bus is released and the strobe is high. With the option clear there is no such cycle.
- R8: With the idle option set, one cycle follows in which strobe, selects and data enable are all inactive and the port is still not ready. With the option clear there is no such cycle.
- R9: Between two consecutive write strobes, the strobe is high for at least two cycles.
- R10: The address clock output is high exactly during the setup cycle.
- R11: Ready is high only while the sequencer is idle, and a request presented while ready is low is ignored. Done is high for exactly the first idle cycle after each write.
- R12: A configuration write during a write cycle does not change that cycle's timing. It applies to requests accepted afterwards.
- R13: Under reset the strobe and all selects are high, the data enable is low, ready is high and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wait | input | WAIT_W | Wait-state count to store |
| cfg_hold | input | 1 | Hold-cycle option to store |
| cfg_idle | input | 1 | Bus-idle-cycle option to store |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Request write data |
| req_bank | input | BSEL_W | Request bank number |
| done | output | 1 | One-cycle pulse after a write completes |
| mem_addr | output | ADDR_W | External address |
| mem_data | output | DATA_W | External write data |
| mem_data_oe | output | 1 | Data-bus driver enable |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_sel_n | output | BANKS | Active-low bank selects |
| mem_adr_clk | output | 1 | Address clock |
| mem_ack | input | 1 | External acknowledge, low extends the strobe |

## Verification
Assertions check the following on every cycle:
- the strobe is preceded by a setup cycle with the address clock high;
- the select is one-hot and active whenever the strobe is low;
- the address is stable while selected;
- the data enable appears only during the strobe or the cycle after it;
- the strobe is held while wait states remain or while the acknowledge is low;
- the strobe has a two-cycle minimum high time;
- the wait counter does not wrap.

Only the bench's scenarios can show exact strobe lengths for given wait counts and acknowledge patterns, the presence or absence of the hold and idle cycles, and the timing of done. They also show that a request made while busy and a configuration write made mid-cycle change nothing.

// File: rtl/ews_pkg.sv
// Shared types for the external write sequencer.
// Assumes: one write in flight at a time.
package ews_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_HOLD,
        ST_GAP
    } ews_state_e;
endpackage

// File: rtl/ews_cfg_reg.sv
// Configuration register: wait-state count, hold option, idle option.
// Assumes: written by a single-cycle enable; all fields reset to zero.
module ews_cfg_reg #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WAIT_W-1:0] wait_in,
    input  logic              hold_in,
    input  logic              idle_in,
    output logic [WAIT_W-1:0] wait_q,
    output logic              hold_q,
    output logic              idle_q
);
    // Store the fields on a write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            hold_q <= 1'b0;
            idle_q <= 1'b0;
        end else if (we) begin
            wait_q <= wait_in;
            hold_q <= hold_in;
            idle_q <= idle_in;
        end
    end
endmodule

// File: rtl/ews_wait_ctr.sv
// Wait-state down counter. It is loaded when a request is accepted and
// counts down during strobe cycles. It reports when no wait states remain.
// Assumes: load and run are never high together.
module ews_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt;

    // Load on accept, decrement toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R3: the count rests at zero and never wraps while running.
    assert_ctr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && expired) |=> expired);
endmodule

// File: rtl/ews_bank_dec.sv
// Decodes a bank number into active-low one-per-bank selects.
// Assumes: bank is below BANKS whenever en is high.
module ews_bank_dec #(
    parameter int BANKS  = 4,
    parameter int BSEL_W = 2
) (
    input  logic [BSEL_W-1:0] bank,
    input  logic              en,
    output logic [BANKS-1:0]  sel_n
);
    // One comparator per select line.
    for (genvar g = 0; g < BANKS; g++) begin : g_sel
        assign sel_n[g] = !(en && (bank == BSEL_W'(g)));
    end
endmodule

// File: rtl/ext_wr_seq.sv
// Asynchronous external memory write sequencer (top).
// Runs one write per request: setup, strobe (wait states plus acknowledge),
// data release, and an optional hold cycle and optional bus-idle cycle.
// Assumes: mem_ack is already synchronised to clk; cfg changes apply at accept.
module ext_wr_seq
    import ews_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BANKS  = 4,
    parameter int WAIT_W = 4,
    localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_hold,
    input  logic              cfg_idle,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BSEL_W-1:0] req_bank,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              mem_data_oe,
    output logic              mem_wr_n,
    output logic [BANKS-1:0]  mem_sel_n,
    output logic              mem_adr_clk,
    input  logic              mem_ack
);
    ews_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BSEL_W-1:0] bank_q;
    logic              hold_opt, idle_opt;
    logic              done_q;
    logic [WAIT_W-1:0] wait_cfg;
    logic              hold_cfg, idle_cfg;
    logic              accept, expired, sel_en;

    ews_cfg_reg #(.WAIT_W(WAIT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .wait_in(cfg_wait), .hold_in(cfg_hold), .idle_in(cfg_idle),
        .wait_q(wait_cfg), .hold_q(hold_cfg), .idle_q(idle_cfg)
    );

    assign accept = req_valid && (state == ST_IDLE);

    ews_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(wait_cfg),
        .run(state == ST_STROBE), .expired(expired)
    );

    // Next-state selection for one write cycle.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = ST_STROBE;
            ST_STROBE:  if (expired && mem_ack) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = hold_opt ? ST_HOLD : (idle_opt ? ST_GAP : ST_IDLE);
            ST_HOLD:    state_nx = idle_opt ? ST_GAP : ST_IDLE;
            ST_GAP:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state != ST_IDLE) && (state_nx == ST_IDLE);
        end
    end

    // Capture the request and the option bits at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            data_q   <= '0;
            bank_q   <= '0;
            hold_opt <= 1'b0;
            idle_opt <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            data_q   <= req_data;
            bank_q   <= req_bank;
            hold_opt <= hold_cfg;
            idle_opt <= idle_cfg;
        end
    end

    assign sel_en = (state == ST_SETUP) || (state == ST_STROBE) ||
                    (state == ST_RELEASE) || (state == ST_HOLD);

    ews_bank_dec #(.BANKS(BANKS), .BSEL_W(BSEL_W)) u_dec (
        .bank(bank_q), .en(sel_en), .sel_n(mem_sel_n)
    );

    assign mem_wr_n    = (state != ST_STROBE);
    assign mem_data_oe = (state == ST_STROBE) || (state == ST_RELEASE);
    assign mem_adr_clk = (state == ST_SETUP);
    assign mem_addr    = addr_q;
    assign mem_data    = data_q;
    assign req_ready   = (state == ST_IDLE);
    assign done        = done_q;

    // R1: the strobe falls only after a setup cycle with the address clock high.
    assert_setup_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(mem_adr_clk));
    // R1: the address is stable while a select stays active.
    assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_sel_n) && !(&$past(mem_sel_n))) |-> $stable(mem_addr));
    // R3: the strobe is held while wait states remain.
    assert_ack_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && !expired) |=> !mem_wr_n);
    // R4: a low acknowledge after the wait states holds the strobe.
    assert_ack_extends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && expired && !mem_ack) |=> !mem_wr_n);
    // R5: the data bus is driven only during the strobe or the cycle after it.
    assert_oe_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_data_oe && mem_wr_n) |-> !$past(mem_wr_n));
    // R6: at most one select is active, and exactly one during the strobe.
    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_sel_n));
    assert_sel_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> ($countones(~mem_sel_n) == 1));
    // R9: the strobe stays high for at least two cycles after it rises.
    assert_min_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |=> mem_wr_n);
    // R11: done appears only while the port is ready.
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/sim_ext_wr_seq.sv
`timescale 1ns/100ps
module sim_ext_wr_seq;
    localparam int AW = 24, DW = 32, NB = 4, WW = 4, BW = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_we, cfg_hold, cfg_idle, req_valid, req_ready, done;
    logic [WW-1:0] cfg_wait;
    logic [AW-1:0] req_addr, mem_addr;
    logic [DW-1:0] req_data, mem_data;
    logic [BW-1:0] req_bank;
    logic mem_data_oe, mem_wr_n, mem_adr_clk, mem_ack;
    logic [NB-1:0] mem_sel_n;

    ext_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .BANKS(NB), .WAIT_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
        .cfg_hold(cfg_hold), .cfg_idle(cfg_idle), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
        .req_bank(req_bank), .done(done), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_data_oe(mem_data_oe), .mem_wr_n(mem_wr_n),
        .mem_sel_n(mem_sel_n), .mem_adr_clk(mem_adr_clk), .mem_ack(mem_ack)
    );

    typedef struct {
        bit wr_n, sel, oe, aclk, ready, dn, ack;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int b;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0, low_cnt = 0, high_run = 0;
    bit seen_low = 0, finished = 0;
    int m_w = 0; bit m_h = 0, m_i = 0;
    logic [AW-1:0] t_a; logic [DW-1:0] t_d; int t_b;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic add(bit wr, bit sel, bit oe, bit ac, bit rdy, bit dn, bit ack);
        exp_t e;
        e.wr_n = wr; e.sel = sel; e.oe = oe; e.aclk = ac; e.ready = rdy;
        e.dn = dn; e.ack = ack; e.a = t_a; e.d = t_d; e.b = t_b;
        exp_q.push_back(e);
    endtask

    // One cycle: compare outputs against the model, then drive the acknowledge.
    task automatic step();
        exp_t e;
        logic [NB-1:0] sel_exp;
        @(negedge clk);
        if (exp_q.size() != 0) e = exp_q.pop_front();
        else begin
            e.wr_n = 1; e.sel = 0; e.oe = 0; e.aclk = 0; e.ready = 1;
            e.dn = 0; e.ack = 1; e.a = '0; e.d = '0; e.b = 0;
        end
        sel_exp = e.sel ? ~(NB'(1) << e.b) : '1;
        chk(mem_wr_n == e.wr_n, "R2", "wr_n", mem_wr_n, e.wr_n);
        chk(mem_data_oe == e.oe, "R5", "data_oe", mem_data_oe, e.oe);
        chk(mem_sel_n == sel_exp, "R6", "sel_n", mem_sel_n, sel_exp);
        chk(mem_adr_clk == e.aclk, "R10", "adr_clk", mem_adr_clk, e.aclk);
        chk(req_ready == e.ready, "R11", "ready", req_ready, e.ready);
        chk(done == e.dn, "R11", "done", done, e.dn);
        if (e.sel) chk(mem_addr == e.a, "R1", "addr", mem_addr, e.a);
        if (e.oe) chk(mem_data == e.d, "R5", "data", mem_data, e.d);
        if (!mem_wr_n) begin
            low_cnt++;
            if (high_run > 0 && seen_low) chk(high_run >= 2, "R9", "high_run", high_run, 2);
            high_run = 0; seen_low = 1;
        end else high_run++;
        mem_ack = e.ack;
    endtask

    task automatic set_cfg(int w, bit h, bit i);
        cfg_we = 1; cfg_wait = WW'(w); cfg_hold = h; cfg_idle = i;
        m_w = w; m_h = h; m_i = i;
        step();
        cfg_we = 0;
    endtask

    // Issue one write with k acknowledge-low cycles after the wait states.
    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, int b, int k,
                            string tag, bit poke, bit mid, int mid_w);
        int w; bit h, i;
        while (exp_q.size() != 0) step();
        w = m_w; h = m_h; i = m_i;
        t_a = a; t_d = d; t_b = b;
        add(1, 1, 0, 1, 0, 0, 0);
        for (int j = 0; j <= w + k; j++) add(0, 1, 1, 0, 0, 0, j >= w + k);
        add(1, 1, 1, 0, 0, 0, 1);
        if (h) add(1, 1, 0, 0, 0, 0, 1);
        if (i) add(1, 0, 0, 0, 0, 0, 1);
        add(1, 0, 0, 0, 1, 1, 1);
        req_valid = 1; req_addr = a; req_data = d; req_bank = BW'(b);
        low_cnt = 0;
        step();
        if (mid) begin
            cfg_we = 1; cfg_wait = WW'(mid_w); m_w = mid_w;
        end
        if (poke) begin
            req_addr = ~a; req_data = ~d; req_bank = BW'(b + 1);
        end else req_valid = 0;
        step();
        cfg_we = 0; req_valid = 0;
        while (exp_q.size() != 0) step();
        chk(low_cnt == w + 1 + k, tag, "strobe_low_cycles", low_cnt, w + 1 + k);
    endtask

    always @(posedge clk) begin : watchdog
        static int wd = 0;
        wd++;
        if (wd >= 100000 && !finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_wait = '0; cfg_hold = 0; cfg_idle = 0;
        req_valid = 0; req_addr = '0; req_data = '0; req_bank = '0; mem_ack = 1;
        repeat (3) @(negedge clk);
        chk(mem_wr_n == 1, "R13", "reset wr_n", mem_wr_n, 1);
        chk(mem_sel_n == '1, "R13", "reset sel_n", mem_sel_n, 4'hf);
        chk(mem_data_oe == 0, "R13", "reset oe", mem_data_oe, 0);
        chk(req_ready == 1, "R13", "reset ready", req_ready, 1);
        chk(done == 0, "R13", "reset done", done, 0);
        rst_n = 1;
        step();
        do_write(24'h000100, 32'hA5A5_0001, 0, 0, "R2", 0, 0, 0);
        do_write(24'h00FFFF, 32'h1234_5678, 3, 0, "R2", 0, 0, 0);
        set_cfg(3, 0, 0);
        do_write(24'h123456, 32'hDEAD_BEEF, 1, 0, "R3", 0, 0, 0);
        set_cfg(2, 0, 0);
        do_write(24'hABCDEF, 32'h0BAD_F00D, 2, 3, "R4", 0, 0, 0);
        do_write(24'h000001, 32'h0000_0001, 3, 1, "R4", 0, 0, 0);
        set_cfg(1, 1, 0);
        do_write(24'h0F0F0F, 32'hCAFE_0007, 0, 0, "R7", 0, 0, 0);
        set_cfg(0, 0, 1);
        do_write(24'h111111, 32'h2222_2222, 1, 0, "R8", 0, 0, 0);
        set_cfg(2, 1, 1);
        do_write(24'h333333, 32'h4444_4444, 2, 2, "R7", 0, 0, 0);
        set_cfg(1, 0, 0);
        do_write(24'h555555, 32'h6666_6666, 3, 0, "R11", 1, 0, 0);
        do_write(24'h777777, 32'h8888_8888, 0, 0, "R12", 0, 1, 4);
        do_write(24'h999999, 32'hAAAA_AAAA, 1, 0, "R12", 0, 0, 0);
        set_cfg(15, 0, 0);
        do_write(24'hFFFFFF, 32'hFFFF_FFFF, 3, 2, "R2", 0, 0, 0);
        set_cfg(0, 0, 0);
        for (int n = 0; n < 4; n++)
            do_write(AW'(24'h400000 + n * 24'h10), DW'(32'h100 * n + 7), n, n % 2, "R9", 0, 0, 0);
        repeat (3) step();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule